// File: doc/BRIEF.md
# Segmented-Page Address Translator

This block turns a 20-bit logical address into a 20-bit physical address. The logical address is split into a segment number, a page number within that segment, and a word offset. Each segment has a descriptor in a small segment table. The descriptor holds a validity flag, a base index into a shared page table, the index of its last legal page, and an access-rights code. The page-table entry at base plus page holds the physical block number. The word offset is appended to that block number unchanged.

A small fully associative lookaside buffer keeps recent segment/page to block translations, together with their rights. A request that hits in it is answered one cycle later without reading either table. A miss reads the segment table and then the page table. It answers two cycles later than a hit, and a successful walk installs the result in the buffer in round-robin order. Both tables are loaded through one write port, and every such write empties the buffer. Requests that name an invalid segment, a page past the segment's end, or a use the segment's rights forbid are answered with a fault and a cause code instead of an address.

Top module: `seg_page_xlate`

## Requirements
- R1: The physical address is {block, word}, where the block is bits [19:8] and the word is bits [7:0]. The word is copied unchanged from logical bits [7:0]. The logical segment is bits [19:16] and the logical page is bits [15:8].
- R2: The page-table index is (segment base + page) modulo 256, and that entry's low 12 bits are the block. Logical 6027E, with segment 6 based at 35h and page-table entries 35h..39h holding 012, 000, 019, 053 and A61, gives 0197E. Two segment/page pairs may share one block.
- R3: A segment-table entry is written with cfg_page_sel=0 and has this layout: [7:0] base, [15:8] last legal page (length minus one, so 1 to 256 pages), [17:16] rights, [18] valid. A page greater than the last legal page is answered with rsp_fault=1 and cause 2.
- R4: A request to a segment whose valid bit is 0 is answered with rsp_fault=1 and cause 1.
- R5: The rights codes are 0 read/write, 1 read-only, 2 execute-only and 3 system-only. A write to code 1, a non-fetch access (req_exec=0) to code 2, and a user access (req_user=1) to code 3 are answered with cause 3. Every other combination translates normally.
- R6: After reset req_ready=1 and rsp_valid=0. A request that misses is answered 3 cycles after it is accepted, and req_ready is low in between.
- R7: A request that hits in the buffer is answered in the cycle after it is accepted, with the same result a walk would give, rights checks included.
- R8: The buffer holds TLB_ENTRIES translations. A walk that ends without a cause 1 or cause 2 fault fills the slot named by a round-robin pointer, which then advances. The pointer returns to slot 0 when the buffer is emptied.
- R9: Any table write (cfg_we=1; cfg_page_sel=1 writes a page entry whose block is cfg_wdata[11:0]) empties the buffer, so the next request misses and sees the new table contents.
- R10: A fault response carries rsp_paddr=0 and a nonzero cause. A good response carries cause 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_page_sel | input | 1 | 0 selects the segment table, 1 selects the page table |
| cfg_addr | input | 8 | Table entry index |
| cfg_wdata | input | 19 | Entry contents |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_laddr | input | 20 | Logical address |
| req_write | input | 1 | Access is a write |
| req_exec | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Access comes from user mode |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | 0 none, 1 bad segment, 2 page out of range, 3 rights |
| rsp_paddr | output | 20 | Physical address |

## Verification
The bench uses the default sizes: 4-bit segment, 8-bit page and word, 12-bit block, and a 4-entry buffer. At these sizes every segment descriptor and all 256 page-table entries can be loaded. Every segment is then swept at its first, second, last and first-illegal page and at page 255, under four access kinds. That covers the rights matrix and the base-plus-page wrap in one pass. Because the buffer is only four entries deep, the sweep keeps overflowing it, so the replacement order and the hit/miss latency are checked against a bench model many times. A full sweep of the 256 word values confirms the offset pass-through.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic [1:0] {
    RIGHT_RW  = 2'd0,
    RIGHT_RO  = 2'd1,
    RIGHT_XO  = 2'd2,
    RIGHT_SYS = 2'd3
  } rights_t;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_SEG   = 2'd1,
    CAUSE_RANGE = 2'd2,
    CAUSE_PROT  = 2'd3
  } cause_t;

  // True when the access kind is not allowed by the rights code
  function automatic logic prot_violation(rights_t r, logic wr, logic ex, logic usr);
    case (r)
      RIGHT_RO:  return wr;
      RIGHT_XO:  return !ex;
      RIGHT_SYS: return usr;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/xlate_sram.sv
module xlate_sram #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // Synchronous write and registered read, suitable for block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int KEY_W   = 12,
  parameter int BLK_W   = 12,
  localparam int PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [KEY_W-1:0] look_key,
  output logic             hit,
  output logic [BLK_W-1:0] hit_blk,
  output rights_t          hit_rights,
  input  logic             ins_en,
  input  logic [KEY_W-1:0] ins_key,
  input  logic [BLK_W-1:0] ins_blk,
  input  rights_t          ins_rights
);

  logic [ENTRIES-1:0] vld;
  logic [ENTRIES-1:0] match;
  logic [KEY_W-1:0]   key_q    [ENTRIES];
  logic [BLK_W-1:0]   blk_q    [ENTRIES];
  rights_t            rights_q [ENTRIES];
  logic [PTR_W-1:0]   ptr;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld[g] && (key_q[g] == look_key);
  end

  assign hit = |match;

  always_comb begin
    hit_blk    = '0;
    hit_rights = RIGHT_RW;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        hit_blk    = blk_q[i];
        hit_rights = rights_q[i];
      end
    end
  end

  // Valid bits and replacement pointer; emptying wins over filling
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld <= '0;
      ptr <= '0;
    end else if (ins_en) begin
      vld[ptr] <= 1'b1;
      ptr      <= (ptr == PTR_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en) begin
      key_q[ptr]    <= ins_key;
      blk_q[ptr]    <= ins_blk;
      rights_q[ptr] <= ins_rights;
    end
  end

endmodule

// File: rtl/seg_page_xlate.sv
module seg_page_xlate
  import xlate_pkg::*;
#(
  parameter int SEG_W       = 4,
  parameter int PAGE_W      = 8,
  parameter int WORD_W      = 8,
  parameter int BLK_W       = 12,
  parameter int TLB_ENTRIES = 4,
  localparam int LA_W   = SEG_W + PAGE_W + WORD_W,
  localparam int PA_W   = BLK_W + WORD_W,
  localparam int SEGS   = 1 << SEG_W,
  localparam int PT_DEP = 1 << PAGE_W,
  localparam int SEGE_W = 2 * PAGE_W + 3,
  localparam int CFG_AW = (SEG_W > PAGE_W) ? SEG_W : PAGE_W,
  localparam int CFG_W  = (SEGE_W > BLK_W) ? SEGE_W : BLK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_page_sel,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LA_W-1:0]   req_laddr,
  input  logic              req_write,
  input  logic              req_exec,
  input  logic              req_user,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [1:0]        rsp_cause,
  output logic [PA_W-1:0]   rsp_paddr
);

  typedef enum logic [1:0] {ST_IDLE, ST_SEG, ST_PAGE} st_t;

  st_t st;

  logic [SEG_W-1:0]  req_seg;
  logic [PAGE_W-1:0] req_page;
  logic [WORD_W-1:0] req_word;
  assign req_seg  = req_laddr[LA_W-1 -: SEG_W];
  assign req_page = req_laddr[WORD_W+PAGE_W-1 -: PAGE_W];
  assign req_word = req_laddr[WORD_W-1:0];

  logic [SEG_W-1:0]  seg_q;
  logic [PAGE_W-1:0] page_q;
  logic [WORD_W-1:0] word_q;
  logic              wr_q, ex_q, usr_q, stale_q;
  cause_t            flt_q;
  rights_t           rights_q;

  logic accept;
  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;

  // Segment descriptor table
  logic [SEGE_W-1:0] seg_rd;
  xlate_sram #(.DEPTH(SEGS), .DW(SEGE_W)) seg_tbl_i (
    .clk   (clk),
    .we    (cfg_we && !cfg_page_sel),
    .waddr (cfg_addr[SEG_W-1:0]),
    .wdata (cfg_wdata[SEGE_W-1:0]),
    .raddr (req_seg),
    .rdata (seg_rd)
  );

  logic [PAGE_W-1:0] d_base, d_last;
  logic              d_valid;
  rights_t           d_rights;
  assign d_base   = seg_rd[PAGE_W-1:0];
  assign d_last   = seg_rd[2*PAGE_W-1:PAGE_W];
  assign d_rights = rights_t'(seg_rd[2*PAGE_W+1:2*PAGE_W]);
  assign d_valid  = seg_rd[2*PAGE_W+2];

  // Page table of block numbers, indexed by base plus page
  logic [PAGE_W-1:0] pt_idx;
  logic [BLK_W-1:0]  pt_rd;
  assign pt_idx = d_base + page_q;

  xlate_sram #(.DEPTH(PT_DEP), .DW(BLK_W)) page_tbl_i (
    .clk   (clk),
    .we    (cfg_we && cfg_page_sel),
    .waddr (cfg_addr[PAGE_W-1:0]),
    .wdata (cfg_wdata[BLK_W-1:0]),
    .raddr (pt_idx),
    .rdata (pt_rd)
  );

  // Lookaside buffer
  logic              tlb_raw_hit, tlb_hit, ins_en;
  logic [BLK_W-1:0]  tlb_blk;
  rights_t           tlb_rights;
  assign tlb_hit = tlb_raw_hit && !cfg_we;
  assign ins_en  = (st == ST_PAGE) && (flt_q == CAUSE_NONE) && !stale_q && !cfg_we;

  xlate_tlb #(.ENTRIES(TLB_ENTRIES), .KEY_W(SEG_W + PAGE_W), .BLK_W(BLK_W)) tlb_i (
    .clk        (clk),
    .rst        (rst),
    .flush      (cfg_we),
    .look_key   ({req_seg, req_page}),
    .hit        (tlb_raw_hit),
    .hit_blk    (tlb_blk),
    .hit_rights (tlb_rights),
    .ins_en     (ins_en),
    .ins_key    ({seg_q, page_q}),
    .ins_blk    (pt_rd),
    .ins_rights (rights_q)
  );

  logic   hit_prot, walk_prot;
  cause_t walk_cause;
  assign hit_prot   = prot_violation(tlb_rights, req_write, req_exec, req_user);
  assign walk_prot  = prot_violation(rights_q, wr_q, ex_q, usr_q);
  assign walk_cause = (flt_q != CAUSE_NONE) ? flt_q :
                      walk_prot ? CAUSE_PROT : CAUSE_NONE;

  // A table write during a walk keeps its result out of the buffer
  always_ff @(posedge clk) begin
    if (rst)         stale_q <= 1'b0;
    else if (accept) stale_q <= cfg_we;
    else             stale_q <= stale_q || cfg_we;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= CAUSE_NONE;
      rsp_paddr <= '0;
      seg_q     <= '0;
      page_q    <= '0;
      word_q    <= '0;
      wr_q      <= 1'b0;
      ex_q      <= 1'b0;
      usr_q     <= 1'b0;
      flt_q     <= CAUSE_NONE;
      rights_q  <= RIGHT_RW;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            seg_q  <= req_seg;
            page_q <= req_page;
            word_q <= req_word;
            wr_q   <= req_write;
            ex_q   <= req_exec;
            usr_q  <= req_user;
            if (tlb_hit) begin
              rsp_valid <= 1'b1;
              rsp_fault <= hit_prot;
              rsp_cause <= hit_prot ? CAUSE_PROT : CAUSE_NONE;
              rsp_paddr <= hit_prot ? '0 : {tlb_blk, req_word};
            end else begin
              st <= ST_SEG;
            end
          end
        end
        ST_SEG: begin
          flt_q    <= !d_valid ? CAUSE_SEG :
                      (page_q > d_last) ? CAUSE_RANGE : CAUSE_NONE;
          rights_q <= d_rights;
          st       <= ST_PAGE;
        end
        default: begin
          rsp_valid <= 1'b1;
          rsp_fault <= (walk_cause != CAUSE_NONE);
          rsp_cause <= walk_cause;
          rsp_paddr <= (walk_cause != CAUSE_NONE) ? '0 : {pt_rd, word_q};
          st        <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/xlate_chk.sv
module xlate_chk #(
  parameter int LA_W   = 20,
  parameter int PA_W   = 20,
  parameter int WORD_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic [LA_W-1:0] req_laddr,
  input logic            rsp_valid,
  input logic            rsp_fault,
  input logic [1:0]      rsp_cause,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            cfg_we,
  input logic            tlb_hit
);

  a_r7_hit_next_cycle: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && tlb_hit) |=> rsp_valid);

  a_r6_miss_holds_off: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !tlb_hit) |=> (!req_ready && !rsp_valid));

  a_r1_word_kept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && tlb_hit) |=>
      (rsp_fault || rsp_paddr[WORD_W-1:0] == $past(req_laddr[WORD_W-1:0])));

  a_r9_write_empties: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> !tlb_hit);

  a_r10_fault_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_cause != 2'd0));

  a_r10_good_cause: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> (rsp_cause == 2'd0));

endmodule

bind seg_page_xlate xlate_chk #(.LA_W(LA_W), .PA_W(PA_W), .WORD_W(WORD_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_laddr (req_laddr),
  .rsp_valid (rsp_valid),
  .rsp_fault (rsp_fault),
  .rsp_cause (rsp_cause),
  .rsp_paddr (rsp_paddr),
  .cfg_we    (cfg_we),
  .tlb_hit   (tlb_hit)
);

// File: tb/seg_page_xlate_tb_top.sv
`timescale 1ns/1ps
module seg_page_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_page_sel = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [18:0] cfg_wdata = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_exec = 1'b0, req_user = 1'b0;
  logic [19:0] req_laddr = '0;
  logic        req_ready, rsp_valid, rsp_fault;
  logic [1:0]  rsp_cause;
  logic [19:0] rsp_paddr;

  always #4 clk = ~clk;

  seg_page_xlate dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_page_sel(cfg_page_sel),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_laddr(req_laddr), .req_write(req_write),
    .req_exec(req_exec), .req_user(req_user), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr)
  );

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  // Bench model of tables and of the buffer
  bit         sv [16];
  logic [7:0] sb [16], sl [16];
  logic [1:0] sr [16];
  logic [11:0] pt [256];
  logic [11:0] tk [4];
  bit          tv [4];
  int          tptr = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic flush_model();
    for (int i = 0; i < 4; i++) tv[i] = 1'b0;
    tptr = 0;
  endtask

  task automatic cfg_wr(input bit psel, input logic [7:0] a, input logic [18:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_page_sel = psel; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    flush_model();   // R9: every table write empties the buffer
    if (psel) pt[a] = d[11:0];
    else begin
      sb[a[3:0]] = d[7:0]; sl[a[3:0]] = d[15:8];
      sr[a[3:0]] = d[17:16]; sv[a[3:0]] = d[18];
    end
  endtask

  task automatic seg_wr(input int s, input bit v, input logic [1:0] r,
                        input logic [7:0] last, input logic [7:0] base);
    cfg_wr(1'b0, 8'(s), {v, r, last, base});
  endtask

  task automatic do_req(input logic [3:0] s, input logic [7:0] p, input logic [7:0] w,
                        input bit wr, input bit ex, input bit usr, input string tag);
    int n, lat, cause;
    bit hit;
    logic [19:0] exp_pa;
    logic [11:0] key;
    key = {s, p};
    hit = 1'b0;
    for (int i = 0; i < 4; i++) if (tv[i] && tk[i] == key) hit = 1'b1;
    lat = hit ? 1 : 3;
    if (!sv[s])          cause = 1;
    else if (p > sl[s])  cause = 2;
    else if ((sr[s] == 2'd1 && wr) || (sr[s] == 2'd2 && !ex) || (sr[s] == 2'd3 && usr)) cause = 3;
    else                 cause = 0;
    exp_pa = (cause != 0) ? 20'h0 : {pt[8'(sb[s] + p)], w};

    @(negedge clk);
    req_valid = 1'b1; req_laddr = {s, p, w};
    req_write = wr; req_exec = ex; req_user = usr;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    if (!hit) chk(req_ready == 1'b0, {"R6 ready low ", tag}, 32'(req_ready), 0);
    while (!rsp_valid && n < 8) begin
      @(negedge clk);
      n++;
    end
    chk(n == lat, hit ? {"R7 latency ", tag} : {"R6 latency ", tag}, 32'(n), 32'(lat));
    chk(rsp_cause == 2'(cause),
        cause == 1 ? {"R4 cause ", tag} : cause == 2 ? {"R3 cause ", tag} :
        cause == 3 ? {"R5 cause ", tag} : {"R10 cause ", tag},
        32'(rsp_cause), 32'(cause));
    chk(rsp_fault == (cause != 0), {"R10 fault ", tag}, 32'(rsp_fault), 32'(cause != 0));
    chk(rsp_paddr == exp_pa, (cause != 0) ? {"R10 paddr ", tag} : {"R2 paddr ", tag},
        32'(rsp_paddr), 32'(exp_pa));
    // R8: good walks fill the round-robin slot
    if (!hit && cause != 1 && cause != 2) begin
      tk[tptr] = key; tv[tptr] = 1'b1; tptr = (tptr + 1) % 4;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    flush_model();
    for (int i = 0; i < 16; i++) begin sv[i] = 0; sb[i] = 0; sl[i] = 0; sr[i] = 0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R6 reset ready", 32'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R6 reset valid", 32'(rsp_valid), 0);

    // Page table: computed pattern, then the scenario entries
    for (int i = 0; i < 256; i++) cfg_wr(1'b1, 8'(i), 19'((i * 37 + 12'h301) & 12'hFFF));
    cfg_wr(1'b1, 8'h35, 19'h012); cfg_wr(1'b1, 8'h36, 19'h000);
    cfg_wr(1'b1, 8'h37, 19'h019); cfg_wr(1'b1, 8'h38, 19'h053);
    cfg_wr(1'b1, 8'h39, 19'hA61); cfg_wr(1'b1, 8'h50, 19'h012);

    // Segment descriptors
    for (int i = 0; i < 16; i++) seg_wr(i, (i >= 7 && i <= 14), 2'd0, 8'(i), 8'(i * 16));
    seg_wr(0, 0, 2'd0, 8'h0F, 8'h00);
    seg_wr(1, 0, 2'd0, 8'h0F, 8'h00);
    seg_wr(2, 1, 2'd0, 8'hFF, 8'hF0);   // 256 pages, index wraps
    seg_wr(3, 1, 2'd2, 8'h03, 8'h10);   // execute-only
    seg_wr(4, 1, 2'd3, 8'h01, 8'h20);   // system-only
    seg_wr(5, 1, 2'd1, 8'h07, 8'h40);   // read-only
    seg_wr(6, 1, 2'd0, 8'h04, 8'h35);
    seg_wr(15, 1, 2'd1, 8'h00, 8'h50);

    // R2 scenario and alias: miss then hit
    do_req(4'h6, 8'h02, 8'h7E, 0, 0, 0, "6027E miss");
    chk(rsp_paddr == 20'h0197E, "R2 scenario", 32'(rsp_paddr), 32'h0197E);
    do_req(4'h6, 8'h02, 8'h7E, 0, 0, 0, "6027E hit R7");
    do_req(4'hF, 8'h00, 8'h00, 0, 0, 0, "alias F0000 R2");
    chk(rsp_paddr == 20'h01200, "R2 alias", 32'(rsp_paddr), 32'h01200);
    do_req(4'h6, 8'h00, 8'h10, 0, 0, 0, "alias 60010 R2");

    // Sweep segments, boundary pages and access kinds (R3 R4 R5)
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 5; k++) begin
        for (int m = 0; m < 4; m++) begin
          logic [7:0] p;
          case (k)
            0: p = 8'd0;
            1: p = 8'd1;
            2: p = sl[s];
            3: p = sl[s] + 8'd1;
            default: p = 8'hFF;
          endcase
          do_req(4'(s), p, 8'(s * 16 + k), m == 1, m == 2, m == 3, "sweep");
        end
      end
    end

    // R8 round-robin order on a freshly emptied buffer
    cfg_wr(1'b1, 8'hFF, 19'(pt[8'hFF]));
    for (int i = 0; i < 4; i++) do_req(4'h7, 8'(i), 8'h00, 0, 0, 0, "R8 fill");
    do_req(4'h7, 8'd0, 8'h01, 0, 0, 0, "R8 hit slot0");
    do_req(4'h7, 8'd4, 8'h02, 0, 0, 0, "R8 evict slot0");
    do_req(4'h7, 8'd1, 8'h03, 0, 0, 0, "R8 hit slot1");
    do_req(4'h7, 8'd0, 8'h04, 0, 0, 0, "R8 evicted miss");
    do_req(4'h7, 8'd1, 8'h05, 0, 0, 0, "R8 evict slot1");

    // R9 table write between two identical requests
    do_req(4'h6, 8'h02, 8'h7E, 0, 0, 0, "R9 warm");
    do_req(4'h6, 8'h02, 8'h7E, 0, 0, 0, "R9 hit");
    cfg_wr(1'b1, 8'h37, 19'h7AB);
    do_req(4'h6, 8'h02, 8'h7E, 0, 0, 0, "R9 after write");
    chk(rsp_paddr == 20'h7AB7E, "R9 new block", 32'(rsp_paddr), 32'h7AB7E);

    // R1 every word offset
    for (int w = 0; w < 256; w++) begin
      do_req(4'h6, 8'h01, 8'(w), 0, 0, 0, "R1 word");
      chk(rsp_paddr[7:0] == 8'(w), "R1 offset", 32'(rsp_paddr[7:0]), 32'(w));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule